// File: doc/BRIEF.md
# Command-Pointer Register-File Serial Slave

This block is a two-wire serial-bus slave that gives a bus master access to a 16-entry byte-wide register map. Every transaction begins with a command byte that loads an internal pointer. The data bytes that follow are written to, or read from, the register the pointer selects. The pointer then moves to the next address after each byte, and it wraps from 0xF back to 0x0. Reads use the combined format: the master first writes the command, then issues a repeated START with the read bit set.

A bit in the command byte selects block mode. For a block write, the byte after the command is a byte count. Only that many data bytes are stored, and any surplus bytes are acknowledged and then dropped. For a block read, the first byte the slave returns is the number of bytes from the pointer to the end of the map. In plain mode there is no count, and the transfer runs until STOP. The map holds seven writable configuration bytes, a constant identifier, four live sensor data bytes, and four holes (three reserved addresses and one test address). The holes read as zero and accept writes without effect. The slave address is one of three parameter values, chosen by a select input that the block captures during reset.

Top module: `i2cRegSlave`

## Requirements
- R1: While `rstN` is low the block captures `addrSel` and answers only to `SLV_ADDR_A` when it is 0, `SLV_ADDR_B` when it is 1 and `SLV_ADDR_C` when it is 2 or 3. Changes to `addrSel` after reset have no effect.
- R2: The address byte is the 7-bit address followed by the read bit in bit 0. A matching address is ACKed (SDA held low in the ninth clock). A non-matching address is not ACKed, and the slave then ACKs nothing until the next START.
- R3: A command byte with bit 7 = 1 is ACKed and loads the pointer from bits 3:0. A byte with bit 7 = 0 is not ACKed, leaves the pointer unchanged, and the slave stays silent until the next START.
- R4: In plain mode (command bit 4 = 0) each data byte is ACKed and stored at the pointer. The pointer then advances by one, wrapping from 0xF to 0x0, until STOP.
- R5: In block mode (command bit 4 = 1) the first byte after the command is a count N. The next N data bytes are stored with auto-increment, and later bytes are ACKed but neither stored nor advance the pointer.
- R6: After a command write, a repeated START and the address with the read bit, the slave returns bytes MSB first starting at the pointer, advancing by one per byte and wrapping from 0xF to 0x0, for as long as the master ACKs.
- R7: When the last command had bit 4 = 1, the first byte of the following read is 16 minus the pointer, and register data follows from the pointer.
- R8: Addresses 0x7, 0x8, 0x9 and 0xB read as 0x00. Writes to them are ACKed and change nothing.
- R9: Address 0xA reads as `ID_VALUE`, and 0xC/0xD/0xE/0xF read as channel-0 low, channel-0 high, channel-1 low and channel-1 high. Writes to these addresses are ACKed and ignored.
- R10: Writable map: 0x0 control, 0x1 timing, 0x2/0x3 low threshold low/high byte, 0x4/0x5 high threshold low/high byte, 0x6 interrupt control. All are 0x00 after reset and are presented on the output ports.
- R11: After the master NACKs a read byte, the slave releases SDA and drives nothing until the next START.
- R12: The slave begins driving SDA only while SCL is low. A START anywhere, including in the middle of a byte, restarts address reception, and a STOP anywhere abandons the transfer without storing the partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state and for bus sampling |
| rstN | input | 1 | Active-low reset; `addrSel` is captured while it is low |
| addrSel | input | 2 | Selects one of three slave addresses |
| sclIn | input | 1 | Serial clock, already synchronised and filtered |
| sdaIn | input | 1 | Serial data as seen on the wire |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| chan0Data | input | 16 | Channel-0 measurement, read at 0xC/0xD |
| chan1Data | input | 16 | Channel-1 measurement, read at 0xE/0xF |
| ctrlReg | output | 8 | Control byte (0x0) |
| timingReg | output | 8 | Timing byte (0x1) |
| thrLow | output | 16 | Low threshold (0x3:0x2) |
| thrHigh | output | 16 | High threshold (0x5:0x4) |
| intCtrlReg | output | 8 | Interrupt control byte (0x6) |

## Verification
The assertions assume that `sclIn` and `sdaIn` are clean, synchronous levels that hold each value for several clocks. They also assume that SDA changes only while SCL is low, except for START and STOP. The bench master drives the bus from the falling clock edge and holds every level for four clocks. It changes data only after lowering SCL, and it creates SDA edges with SCL high only on purpose, in its START and STOP tasks, including one START and one STOP placed in the middle of a byte.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  localparam int REG_W     = 8;
  localparam int MAP_AW    = 4;
  localparam int MAP_DEPTH = 1 << MAP_AW;
  localparam int NUM_CFG   = 7;
  localparam int CH_W      = 2 * REG_W;

  localparam int CMD_VALID_BIT = 7;
  localparam int CMD_BLOCK_BIT = 4;

  localparam logic [MAP_AW-1:0] ADR_ID   = 4'hA;
  localparam logic [MAP_AW-1:0] ADR_CH0L = 4'hC;
  localparam logic [MAP_AW-1:0] ADR_CH0H = 4'hD;
  localparam logic [MAP_AW-1:0] ADR_CH1L = 4'hE;
  localparam logic [MAP_AW-1:0] ADR_CH1H = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_RX, ST_ACKOUT, ST_TX, ST_ACKIN
  } busState_t;

  typedef enum logic [1:0] {PH_CMD, PH_CNT, PH_DATA} wrPhase_t;

  typedef struct packed {
    logic             cmdWr;
    logic             cntWr;
    logic             dataWr;
    logic             rdTake;
    logic [REG_W-1:0] rxByte;
  } dpStrobe_t;

endpackage

// File: rtl/i2cSlaveCtrl.sv
module i2cSlaveCtrl
  import i2cRegPkg::*;
#(
  parameter logic [6:0] ADDR_SEL0 = 7'h2A,
  parameter logic [6:0] ADDR_SEL1 = 7'h3C,
  parameter logic [6:0] ADDR_SEL2 = 7'h4E
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       addrSel,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [REG_W-1:0] rdByte,
  output dpStrobe_t        stb,
  output logic             sdaOe
);

  localparam int BIT_CW = $clog2(REG_W);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(REG_W - 1);

  logic [6:0]        myAddr;
  logic              sclD, sdaD;
  logic              sclRise, sclFall, startDet, stopDet;
  busState_t         state;
  wrPhase_t          phase;
  logic [BIT_CW-1:0] bitCnt;
  logic [REG_W-1:0]  shReg, txReg;
  logic              got8, nextTx, mAck;
  logic              byteEnd, byteAck, loadTx;

  // slave address chosen once, while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      case (addrSel)
        2'd0:    myAddr <= ADDR_SEL0;
        2'd1:    myAddr <= ADDR_SEL1;
        default: myAddr <= ADDR_SEL2;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclIn;
      sdaD <= sdaIn;
    end
  end

  assign sclRise  = sclIn & ~sclD;
  assign sclFall  = ~sclIn & sclD;
  assign startDet = sclIn & sclD & sdaD & ~sdaIn;
  assign stopDet  = sclIn & sclD & ~sdaD & sdaIn;

  assign byteEnd = (state == ST_ADDR || state == ST_RX) && sclFall && got8
                   && !startDet && !stopDet;

  always_comb begin
    byteAck = 1'b0;
    if (state == ST_ADDR)    byteAck = (shReg[7:1] == myAddr);
    else if (state == ST_RX) byteAck = (phase != PH_CMD) || shReg[CMD_VALID_BIT];
  end

  assign loadTx = sclFall && !startDet && !stopDet &&
                  ((state == ST_ACKOUT && nextTx) || (state == ST_ACKIN && mAck));

  always_comb begin
    stb.cmdWr  = byteEnd && state == ST_RX && phase == PH_CMD && shReg[CMD_VALID_BIT];
    stb.cntWr  = byteEnd && state == ST_RX && phase == PH_CNT;
    stb.dataWr = byteEnd && state == ST_RX && phase == PH_DATA;
    stb.rdTake = loadTx;
    stb.rxByte = shReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= PH_CMD;
      bitCnt <= '0;
      shReg  <= '0;
      txReg  <= '0;
      got8   <= 1'b0;
      nextTx <= 1'b0;
      mAck   <= 1'b0;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      got8   <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
      got8  <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (sclRise) begin
            shReg  <= {shReg[REG_W-2:0], sdaIn};
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) got8 <= 1'b1;
          end else if (byteEnd) begin
            got8  <= 1'b0;
            state <= byteAck ? ST_ACKOUT : ST_IDLE;
            if (state == ST_ADDR) begin
              nextTx <= shReg[0];
              phase  <= PH_CMD;
            end else begin
              nextTx <= 1'b0;
              if (phase == PH_CMD)
                phase <= shReg[CMD_BLOCK_BIT] ? PH_CNT : PH_DATA;
              else
                phase <= PH_DATA;
            end
          end
        end
        ST_ACKOUT: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (nextTx) begin
              state <= ST_TX;
              txReg <= rdByte;
            end else begin
              state <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              state <= ST_ACKIN;
            end else begin
              txReg  <= {txReg[REG_W-2:0], 1'b0};
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_ACKIN: begin
          if (sclRise) begin
            mAck <= ~sdaIn;
          end else if (sclFall) begin
            if (mAck) begin
              state  <= ST_TX;
              txReg  <= rdByte;
              bitCnt <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = (state == ST_ACKOUT) || (state == ST_TX && !txReg[REG_W-1]);

  // R12
  sda_drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(sclIn));

  // R2
  addr_miss_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteEnd && state == ST_ADDR && shReg[7:1] != myAddr) |=> (state == ST_IDLE && !sdaOe));

  // R3
  bad_cmd_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteEnd && state == ST_RX && phase == PH_CMD && !shReg[CMD_VALID_BIT]) |=> !sdaOe);

  // R11
  master_nack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACKIN && sclFall && !mAck && !startDet && !stopDet) |=> (state == ST_IDLE && !sdaOe));

  // R12
  start_restarts_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && !sdaOe));

endmodule

// File: rtl/i2cRegDp.sv
module i2cRegDp
  import i2cRegPkg::*;
#(
  parameter logic [REG_W-1:0] ID_VALUE = 8'h5A
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [CH_W-1:0]  chan0Data,
  input  logic [CH_W-1:0]  chan1Data,
  output logic [REG_W-1:0] rdByte,
  output logic [REG_W-1:0] ctrlReg,
  output logic [REG_W-1:0] timingReg,
  output logic [CH_W-1:0]  thrLow,
  output logic [CH_W-1:0]  thrHigh,
  output logic [REG_W-1:0] intCtrlReg
);

  localparam int CFG_IW = $clog2(NUM_CFG);

  logic [MAP_AW-1:0]               ptr;
  logic                            blockMode, cntPending;
  logic [REG_W-1:0]                remain;
  logic                            wrEn;
  logic [NUM_CFG-1:0][REG_W-1:0]   cfgArr;
  logic [REG_W-1:0]                regVal;

  // block mode drops bytes past the count
  assign wrEn = stb.dataWr && (!blockMode || remain != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr        <= '0;
      blockMode  <= 1'b0;
      cntPending <= 1'b0;
      remain     <= '0;
    end else if (stb.cmdWr) begin
      ptr        <= stb.rxByte[MAP_AW-1:0];
      blockMode  <= stb.rxByte[CMD_BLOCK_BIT];
      cntPending <= stb.rxByte[CMD_BLOCK_BIT];
      remain     <= '0;
    end else if (stb.cntWr) begin
      remain     <= stb.rxByte;
      cntPending <= 1'b0;
    end else if (wrEn) begin
      ptr <= ptr + 1'b1;
      if (blockMode) remain <= remain - 1'b1;
    end else if (stb.rdTake) begin
      if (cntPending) cntPending <= 1'b0;
      else            ptr        <= ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : gCfg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              q <= '0;
      else if (wrEn && ptr == MAP_AW'(g))     q <= stb.rxByte;
    end
    assign cfgArr[g] = q;
  end

  always_comb begin
    regVal = '0;
    if (ptr < MAP_AW'(NUM_CFG)) begin
      regVal = cfgArr[ptr[CFG_IW-1:0]];
    end else begin
      case (ptr)
        ADR_ID:   regVal = ID_VALUE;
        ADR_CH0L: regVal = chan0Data[REG_W-1:0];
        ADR_CH0H: regVal = chan0Data[CH_W-1:REG_W];
        ADR_CH1L: regVal = chan1Data[REG_W-1:0];
        ADR_CH1H: regVal = chan1Data[CH_W-1:REG_W];
        default:  regVal = '0;
      endcase
    end
  end

  assign rdByte = cntPending ? (REG_W'(MAP_DEPTH) - REG_W'(ptr)) : regVal;

  assign ctrlReg    = cfgArr[0];
  assign timingReg  = cfgArr[1];
  assign thrLow     = {cfgArr[3], cfgArr[2]};
  assign thrHigh    = {cfgArr[5], cfgArr[4]};
  assign intCtrlReg = cfgArr[6];

  // R5
  remain_no_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cntWr |=> (remain <= $past(remain)));

  // R6
  read_ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdTake && !cntPending && !stb.cmdWr && !stb.cntWr && !stb.dataWr)
      |=> (ptr == $past(ptr) + 1'b1));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.dataWr |=> $stable(cfgArr));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cmdWr, stb.cntWr, stb.dataWr, stb.rdTake}));

endmodule

// File: rtl/i2cRegSlave.sv
module i2cRegSlave
  import i2cRegPkg::*;
#(
  parameter logic [6:0]       SLV_ADDR_A = 7'h2A,
  parameter logic [6:0]       SLV_ADDR_B = 7'h3C,
  parameter logic [6:0]       SLV_ADDR_C = 7'h4E,
  parameter logic [REG_W-1:0] ID_VALUE   = 8'h5A
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       addrSel,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  input  logic [CH_W-1:0]  chan0Data,
  input  logic [CH_W-1:0]  chan1Data,
  output logic [REG_W-1:0] ctrlReg,
  output logic [REG_W-1:0] timingReg,
  output logic [CH_W-1:0]  thrLow,
  output logic [CH_W-1:0]  thrHigh,
  output logic [REG_W-1:0] intCtrlReg
);

  dpStrobe_t        stb;
  logic [REG_W-1:0] rdByte;

  i2cSlaveCtrl #(
    .ADDR_SEL0(SLV_ADDR_A),
    .ADDR_SEL1(SLV_ADDR_B),
    .ADDR_SEL2(SLV_ADDR_C)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .addrSel (addrSel),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .rdByte  (rdByte),
    .stb     (stb),
    .sdaOe   (sdaOe)
  );

  i2cRegDp #(
    .ID_VALUE(ID_VALUE)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .chan0Data  (chan0Data),
    .chan1Data  (chan1Data),
    .rdByte     (rdByte),
    .ctrlReg    (ctrlReg),
    .timingReg  (timingReg),
    .thrLow     (thrLow),
    .thrHigh    (thrHigh),
    .intCtrlReg (intCtrlReg)
  );

endmodule

// File: tb/i2cRegSlave_tb_top.sv
module i2cRegSlave_tb_top;

  localparam logic [15:0] CH0 = 16'hB00F;
  localparam logic [15:0] CH1 = 16'h5EA7;
  localparam logic [7:0]  IDV = 8'h5A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic [1:0]  addrSel = 2'd0;
  logic        sclM = 1'b1, sdaM = 1'b1;
  logic        sdaOe, sdaLine;
  logic [7:0]  ctrlReg, timingReg, intCtrlReg;
  logic [15:0] thrLow, thrHigh;

  assign sdaLine = sdaM & ~sdaOe;

  i2cRegSlave dut_i (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .chan0Data(CH0), .chan1Data(CH1), .ctrlReg(ctrlReg),
    .timingReg(timingReg), .thrLow(thrLow), .thrHigh(thrHigh), .intCtrlReg(intCtrlReg)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model [16];
  logic [6:0] myA;

  function automatic logic [6:0] addrOf(int s);
    case (s)
      0:       return 7'h2A;
      1:       return 7'h3C;
      default: return 7'h4E;
    endcase
  endfunction

  function automatic logic [7:0] expRead(int a);
    if (a < 7) return model[a];
    case (a)
      10:      return IDV;
      12:      return CH0[7:0];
      13:      return CH0[15:8];
      14:      return CH1[7:0];
      15:      return CH1[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] pat(int i);
    return 8'(i * 37 + 11);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (4) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; hp(); sclM = 1'b1; hp(); sdaM = 1'b0; hp(); sclM = 1'b0; hp();
  endtask

  task automatic busStop();
    sclM = 1'b0; sdaM = 1'b0; hp(); sclM = 1'b1; hp(); sdaM = 1'b1; hp();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; hp(); sclM = 1'b1; hp(); sclM = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    sendBits(b, 8);
    sdaM = 1'b1; hp(); sclM = 1'b1; hp(); ack = !sdaLine; sclM = 1'b0;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); sclM = 1'b1; hp(); b[i] = sdaLine; sclM = 1'b0;
    end
    sdaM = !giveAck; hp(); sclM = 1'b1; hp(); sclM = 1'b0; hp(); sdaM = 1'b1;
  endtask

  task automatic doReset(input logic [1:0] sel);
    addrSel = sel; rstN = 1'b0; repeat (3) @(negedge clk); rstN = 1'b1; hp();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;

    // R1 R2: address select captured in reset, later changes ignored
    for (int s = 0; s < 4; s++) begin
      doReset(2'(s));
      addrSel = 2'(s + 1);
      for (int a = 0; a < 3; a++) begin
        busStart(); sendByte({addrOf(a), 1'b0}, ack); busStop();
        chk($sformatf("R1 sel%0d addr%0d ack", s, a), int'(ack), int'(a == ((s > 2) ? 2 : s)));
      end
    end
    doReset(2'd0);
    myA = addrOf(0);

    // R10 reset state
    chk("R10 reset ctrl", ctrlReg, 0);
    chk("R10 reset timing", timingReg, 0);
    chk("R10 reset thresholds", {thrLow, thrHigh}, 0);
    chk("R10 reset intctrl", intCtrlReg, 0);

    // R2 wrong address, later bytes also unanswered
    busStart(); sendByte({7'h11, 1'b0}, ack); chk("R2 miss nack", ack, 0);
    sendByte(8'h80, ack); chk("R2 silent after miss", ack, 0); busStop();

    // R4 R8 R9 plain write sweep across whole map with wrap
    busStart(); sendByte({myA, 1'b0}, ack); chk("R2 match ack", ack, 1);
    sendByte(8'h80, ack); chk("R3 cmd ack", ack, 1);
    for (int i = 0; i < 17; i++) begin
      sendByte(pat(i), ack);
      chk($sformatf("R4 data ack %0d", i), ack, 1);
      if ((i % 16) < 7) model[i % 16] = pat(i);
    end
    busStop();
    chk("R10 ctrl map", ctrlReg, model[0]);
    chk("R10 timing map", timingReg, model[1]);
    chk("R10 low thr map", thrLow, {model[3], model[2]});
    chk("R10 high thr map", thrHigh, {model[5], model[4]});
    chk("R10 intctrl map", intCtrlReg, model[6]);

    // R6 R8 R9 combined read sweep with wrap, then R11 release
    busStart(); sendByte({myA, 1'b0}, ack); sendByte(8'h80, ack);
    busStart(); sendByte({myA, 1'b1}, ack); chk("R6 read addr ack", ack, 1);
    for (int i = 0; i < 18; i++) begin
      recvByte(i < 17, rb);
      chk($sformatf("R6 R8 R9 read at %0h", i % 16), rb, expRead(i % 16));
    end
    recvByte(1'b0, rb); chk("R11 released after nack", rb, 8'hFF);
    busStop();

    // R5 block write: count 3, five bytes sent
    busStart(); sendByte({myA, 1'b0}, ack); sendByte(8'h92, ack);
    chk("R5 block cmd ack", ack, 1);
    sendByte(8'd3, ack); chk("R5 count ack", ack, 1);
    for (int i = 0; i < 5; i++) begin
      sendByte(8'hC0 + 8'(i), ack);
      chk($sformatf("R5 block byte ack %0d", i), ack, 1);
      if (i < 3) model[2 + i] = 8'hC0 + 8'(i);
    end
    busStop();
    chk("R5 low thr", thrLow, {model[3], model[2]});
    chk("R5 high thr", thrHigh, {model[5], model[4]});
    chk("R5 intctrl untouched", intCtrlReg, model[6]);

    // R7 block read count for every pointer
    for (int p = 0; p < 16; p++) begin
      busStart(); sendByte({myA, 1'b0}, ack); sendByte(8'h90 | 8'(p), ack);
      busStart(); sendByte({myA, 1'b1}, ack);
      recvByte(1'b1, rb); chk($sformatf("R7 count ptr %0d", p), rb, 16 - p);
      recvByte(1'b0, rb); chk($sformatf("R7 data ptr %0d", p), rb, expRead(p));
      busStop();
    end

    // R3 invalid command keeps pointer
    busStart(); sendByte({myA, 1'b0}, ack); sendByte(8'h83, ack); busStop();
    busStart(); sendByte({myA, 1'b0}, ack); sendByte(8'h05, ack);
    chk("R3 bad cmd nack", ack, 0); busStop();
    busStart(); sendByte({myA, 1'b1}, ack); recvByte(1'b0, rb); busStop();
    chk("R3 pointer kept", rb, expRead(3));

    // R12 start inside a byte, then a complete write
    busStart(); sendBits(8'hA5, 4);
    busStart(); sendByte({myA, 1'b0}, ack); chk("R12 restart addr ack", ack, 1);
    sendByte(8'h81, ack); sendByte(8'h3C, ack); busStop();
    model[1] = 8'h3C;
    chk("R12 write after restart", timingReg, 8'h3C);

    // R12 stop inside a data byte stores nothing
    busStart(); sendByte({myA, 1'b0}, ack); sendByte(8'h81, ack);
    sendBits(8'hC3, 3); busStop();
    chk("R12 partial byte dropped", timingReg, model[1]);
    busStart(); sendByte({myA, 1'b0}, ack); sendByte(8'h86, ack);
    sendByte(8'h99, ack); busStop();
    chk("R12 recovery write", intCtrlReg, 8'h99);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule